// File: doc/BRIEF.md
# Doubleword Exclusive Access Sequencer

This block carries out one 64-bit exclusive load or exclusive store for a core that only has a 32-bit memory bus. The core hands over one request with valid/ready handshaking: the operation kind, a byte address, two store words and a flag that marks the target region as shared. The block checks the alignment. It asks an external exclusive monitor whether the requester still holds the reservation and then runs the two word beats as one locked burst. When the operation ends it raises a one-cycle done pulse that carries a fault flag, an abort flag, the store status and the two load words.

A load tags the 8-byte region in the monitor: always in the local monitor, and also in the global monitor when the region is shared. A store writes memory only while the reservation still holds. It reports 0 when it wrote and 1 when it was refused, and afterwards it tells the monitor what to clear. A bus abort on either beat ends the operation at once. An aborted operation changes neither the load results nor the status, and it takes no monitor action.

Top module: `excl_dword_seq`

## Requirements
- R1: A request whose address has any of bits [2:0] set completes with doneFault=1 and doneAbort=0. It issues no bus beat, no monitor query and no monitor mark or clear.
- R2: An aligned operation issues exactly two beats. The first is at the base address and the second at base+4. doneWord0 is the word read at the base address, and the store word reqWord0 is written at the base address.
- R3: busLock is high during every beat, and it stays high without a gap from the first beat until the second beat is acknowledged.
- R4: A successful load pulses monMarkLocal with monAddr equal to the base address. When reqShared=1 it also pulses monMarkGlobal.
- R5: A store raises monQuery for one cycle before any beat. It issues beats only if monLocalHit=1 and, when reqShared=1, also monGlobalHit=1.
- R6: doneStatus is 0 after a store that wrote both words and 1 after a store refused by the monitor check.
- R7: Every store that wrote or was refused pulses monClearLocal. A successful shared store also pulses monClearAddr for the base address.
- R8: On a bus abort (busErr=1 with busAck=1), the operation completes with doneAbort=1. doneWord0, doneWord1 and doneStatus keep their previous values, and no monitor mark or clear is issued.
- R9: An abort on the first beat prevents the second beat, so an aborted first store beat leaves memory unchanged.
- R10: reqReady is high only while idle. Each accepted request yields exactly one doneValid pulse before the next request is accepted. After reset, reqReady=1, doneValid=0, busReq=0, busLock=0, doneStatus=0 and both load words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Block idle and able to accept |
| reqIsStore | input | 1 | 1 = exclusive store, 0 = exclusive load |
| reqShared | input | 1 | Target region is shared |
| reqAddr | input | 32 | Byte address of the doubleword |
| reqWord0 | input | 32 | Store word for the base address |
| reqWord1 | input | 32 | Store word for base+4 |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Alignment fault |
| doneAbort | output | 1 | Bus abort |
| doneStatus | output | 1 | Store result: 0 written, 1 refused |
| doneWord0 | output | 32 | Load word from the base address |
| doneWord1 | output | 32 | Load word from base+4 |
| busReq | output | 1 | Beat request, held until acknowledged |
| busAck | input | 1 | Beat acknowledged |
| busErr | input | 1 | Beat aborted, valid with busAck |
| busWrite | output | 1 | Beat is a write |
| busLock | output | 1 | Burst lock |
| busAddr | output | 32 | Beat address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with busAck |
| monQuery | output | 1 | Monitor query strobe |
| monAddr | output | 32 | Address for query, mark and clear |
| monLocalHit | input | 1 | Local monitor holds monAddr |
| monGlobalHit | input | 1 | Global monitor holds monAddr |
| monMarkLocal | output | 1 | Tag region in local monitor |
| monMarkGlobal | output | 1 | Tag region in global monitor |
| monClearLocal | output | 1 | Clear requester's local monitor |
| monClearAddr | output | 1 | Clear all entries for monAddr |

## Verification
The assertions check on every cycle that a misaligned request goes straight to a fault with no bus or monitor traffic. They also check that the lock covers every beat and the join between the two beats, and that the second beat sits four bytes above the first. Further cycle-level checks cover the following. A store beat never starts without a local hit in the query cycle. An abort stops the burst at once and freezes the result outputs. Marks and clears appear only on clean completions.

Whether the store status and the monitor's final state agree with the reservation history can only be shown by the bench scenarios. The same holds for whether memory holds the right words in the right order, and whether a shared store fails after another master steals the global reservation. The bench scenarios cover these over directed and random sequences.

// File: rtl/excl_seq_pkg.sv
package excl_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_BEAT0,
    S_BEAT1,
    S_FIN
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic capLow;
    logic commitLoad;
    logic commitStatus;
    logic statusVal;
    logic beatHigh;
  } dpStrobe_t;
endpackage

// File: rtl/excl_dpath.sv
module excl_dpath
  import excl_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWord0,
  input  logic [DATA_W-1:0] reqWord1,
  input  logic              reqIsStore,
  input  logic              reqShared,
  input  logic [DATA_W-1:0] busRdata,
  output logic              misaligned,
  output logic              latStore,
  output logic              latShared,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [ADDR_W-1:0] monAddr,
  output logic [DATA_W-1:0] doneWord0,
  output logic [DATA_W-1:0] doneWord1,
  output logic              doneStatus
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(2 * BEAT_BYTES);

  logic [ADDR_W-1:0] baseQ;
  logic [DATA_W-1:0] w0Q, w1Q, lowQ;

  assign misaligned = |reqAddr[ALIGN_BITS-1:0];
  assign monAddr    = baseQ;
  assign busAddr    = baseQ + (strb.beatHigh ? ADDR_W'(BEAT_BYTES) : '0);
  assign busWdata   = strb.beatHigh ? w1Q : w0Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      w0Q        <= '0;
      w1Q        <= '0;
      lowQ       <= '0;
      latStore   <= 1'b0;
      latShared  <= 1'b0;
      doneWord0  <= '0;
      doneWord1  <= '0;
      doneStatus <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        baseQ     <= reqAddr;
        w0Q       <= reqWord0;
        w1Q       <= reqWord1;
        latStore  <= reqIsStore;
        latShared <= reqShared;
      end
      if (strb.capLow) lowQ <= busRdata;
      if (strb.commitLoad) begin
        doneWord0 <= lowQ;
        doneWord1 <= busRdata;
      end
      if (strb.commitStatus) doneStatus <= strb.statusVal;
    end
  end

  // R2: the low word committed is the one captured from the first beat
  p_low_word_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitLoad |=> (doneWord0 == $past(lowQ)));
endmodule

// File: rtl/excl_ctrl.sv
module excl_ctrl
  import excl_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqIsStore,
  input  logic      misaligned,
  input  logic      latStore,
  input  logic      latShared,
  input  logic      monLocalHit,
  input  logic      monGlobalHit,
  input  logic      busAck,
  input  logic      busErr,
  output logic      reqReady,
  output logic      busReq,
  output logic      busWrite,
  output logic      busLock,
  output logic      monQuery,
  output logic      monMarkLocal,
  output logic      monMarkGlobal,
  output logic      monClearLocal,
  output logic      monClearAddr,
  output logic      doneValid,
  output logic      doneFault,
  output logic      doneAbort,
  output dpStrobe_t strb
);
  seqState_t stateQ, stateD;
  logic faultQ, abortQ, okQ, failQ;
  logic setAbort, setOk, setFail, checkPass;

  assign checkPass = monLocalHit && (!latShared || monGlobalHit);

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    setAbort = 1'b0;
    setOk    = 1'b0;
    setFail  = 1'b0;
    case (stateQ)
      S_IDLE: if (reqValid) begin
        strb.latchReq = 1'b1;
        if (misaligned)      stateD = S_FIN;
        else if (reqIsStore) stateD = S_CHECK;
        else                 stateD = S_BEAT0;
      end
      S_CHECK: if (checkPass) stateD = S_BEAT0;
      else begin
        strb.commitStatus = 1'b1;
        strb.statusVal    = 1'b1;
        setFail           = 1'b1;
        stateD            = S_FIN;
      end
      S_BEAT0: if (busAck) begin
        if (busErr) begin
          setAbort = 1'b1;
          stateD   = S_FIN;
        end else begin
          strb.capLow = 1'b1;
          stateD      = S_BEAT1;
        end
      end
      S_BEAT1: begin
        strb.beatHigh = 1'b1;
        if (busAck) begin
          stateD = S_FIN;
          if (busErr) setAbort = 1'b1;
          else begin
            setOk = 1'b1;
            if (latStore) strb.commitStatus = 1'b1;
            else          strb.commitLoad   = 1'b1;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      faultQ <= 1'b0;
      abortQ <= 1'b0;
      okQ    <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.latchReq) begin
        faultQ <= misaligned;
        abortQ <= 1'b0;
        okQ    <= 1'b0;
        failQ  <= 1'b0;
      end else begin
        if (setAbort) abortQ <= 1'b1;
        if (setOk)    okQ    <= 1'b1;
        if (setFail)  failQ  <= 1'b1;
      end
    end
  end

  assign reqReady      = (stateQ == S_IDLE);
  assign busReq        = (stateQ == S_BEAT0) || (stateQ == S_BEAT1);
  assign busLock       = busReq;
  assign busWrite      = busReq && latStore;
  assign monQuery      = (stateQ == S_CHECK);
  assign doneValid     = (stateQ == S_FIN);
  assign doneFault     = doneValid && faultQ;
  assign doneAbort     = doneValid && abortQ;
  assign monMarkLocal  = doneValid && !latStore && okQ;
  assign monMarkGlobal = monMarkLocal && latShared;
  assign monClearLocal = doneValid && latStore && (okQ || failQ);
  assign monClearAddr  = doneValid && latStore && okQ && latShared;

  p_fault_no_bus_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && misaligned) |=> (doneValid && doneFault && !busReq && !monQuery));
  p_lock_on_beat_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busLock);
  p_lock_joins_beats_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BEAT0 && busAck && !busErr) |=> (busReq && busLock));
  p_store_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busReq) && busWrite) |-> $past(monQuery && monLocalHit));
  p_refused_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (monQuery && !monLocalHit) |=> (doneValid && !doneAbort && !busReq));
  p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busErr) |=> (!busReq && doneValid && doneAbort));
  p_clean_monitor_r8: assert property (@(posedge clk) disable iff (!rstN)
    (monMarkLocal || monClearLocal || monClearAddr) |-> (doneValid && !doneFault && !doneAbort));
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busReq && !doneValid && !monQuery));
endmodule

// File: rtl/excl_dword_seq.sv
module excl_dword_seq
  import excl_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsStore,
  input  logic              reqShared,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWord0,
  input  logic [DATA_W-1:0] reqWord1,
  output logic              doneValid,
  output logic              doneFault,
  output logic              doneAbort,
  output logic              doneStatus,
  output logic [DATA_W-1:0] doneWord0,
  output logic [DATA_W-1:0] doneWord1,
  output logic              busReq,
  input  logic              busAck,
  input  logic              busErr,
  output logic              busWrite,
  output logic              busLock,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              monQuery,
  output logic [ADDR_W-1:0] monAddr,
  input  logic              monLocalHit,
  input  logic              monGlobalHit,
  output logic              monMarkLocal,
  output logic              monMarkGlobal,
  output logic              monClearLocal,
  output logic              monClearAddr
);
  localparam int BEAT_BYTES = DATA_W / 8;

  dpStrobe_t strb;
  logic misaligned, latStore, latShared;

  excl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .misaligned(misaligned), .latStore(latStore), .latShared(latShared),
    .monLocalHit(monLocalHit), .monGlobalHit(monGlobalHit),
    .busAck(busAck), .busErr(busErr), .reqReady(reqReady), .busReq(busReq),
    .busWrite(busWrite), .busLock(busLock), .monQuery(monQuery),
    .monMarkLocal(monMarkLocal), .monMarkGlobal(monMarkGlobal),
    .monClearLocal(monClearLocal), .monClearAddr(monClearAddr),
    .doneValid(doneValid), .doneFault(doneFault), .doneAbort(doneAbort),
    .strb(strb)
  );

  excl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWord0(reqWord0), .reqWord1(reqWord1), .reqIsStore(reqIsStore),
    .reqShared(reqShared), .busRdata(busRdata), .misaligned(misaligned),
    .latStore(latStore), .latShared(latShared), .busAddr(busAddr),
    .busWdata(busWdata), .monAddr(monAddr), .doneWord0(doneWord0),
    .doneWord1(doneWord1), .doneStatus(doneStatus)
  );

  p_second_beat_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLow |=> (busReq && busAddr == $past(busAddr) + ADDR_W'(BEAT_BYTES)));
  p_abort_freezes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAbort) |-> ($stable(doneWord0) && $stable(doneWord1) && $stable(doneStatus)));
endmodule

// File: tb/excl_dword_seq_bench.sv
module excl_dword_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic reqValid = 1'b0, reqIsStore = 1'b0, reqShared = 1'b0;
  logic [31:0] reqAddr = '0, reqWord0 = '0, reqWord1 = '0;
  logic reqReady, doneValid, doneFault, doneAbort, doneStatus;
  logic [31:0] doneWord0, doneWord1;
  logic busReq, busWrite, busLock;
  logic busAck, busErr;
  logic [31:0] busAddr, busWdata, busRdata, monAddr;
  logic monQuery, monLocalHit, monGlobalHit;
  logic monMarkLocal, monMarkGlobal, monClearLocal, monClearAddr;

  excl_dword_seq u_excl_dword_seq (.*);

  // bench-side memory, bus responder and exclusive monitor
  logic [31:0] mem [16];
  logic locV, gloV;
  logic [31:0] locA, gloA;
  logic stealReq = 1'b0;
  int errBeatSel = 0;
  int beatTotal, opStart, addrErrs, lockErrs, pulseTotal, queryTotal;
  logic [31:0] opBase = '0;

  assign monLocalHit  = locV && (locA == monAddr);
  assign monGlobalHit = gloV && (gloA == monAddr);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i * 32'h0101_0101;
      busAck <= 1'b0; busErr <= 1'b0; busRdata <= '0;
      locV <= 1'b0; gloV <= 1'b0; locA <= '0; gloA <= '0;
      beatTotal <= 0; addrErrs <= 0; lockErrs <= 0; pulseTotal <= 0; queryTotal <= 0;
    end else begin
      if (busReq && busAck) begin
        busAck <= 1'b0;
        busErr <= 1'b0;
        beatTotal <= beatTotal + 1;
        if (busAddr != opBase + 32'(4 * (beatTotal - opStart))) addrErrs <= addrErrs + 1;
        if (busWrite && !busErr) mem[busAddr[5:2]] <= busWdata;
      end else if (busReq && ($urandom % 3 == 0)) begin
        busAck   <= 1'b1;
        busErr   <= (errBeatSel == beatTotal - opStart + 1);
        busRdata <= mem[busAddr[5:2]];
      end
      if (busReq && !busLock) lockErrs <= lockErrs + 1;
      if (monQuery) queryTotal <= queryTotal + 1;
      if (monMarkLocal || monMarkGlobal || monClearLocal || monClearAddr)
        pulseTotal <= pulseTotal + 1;
      if (monMarkLocal)  begin locV <= 1'b1; locA <= monAddr; end
      if (monMarkGlobal) begin gloV <= 1'b1; gloA <= monAddr; end
      if (monClearLocal) locV <= 1'b0;
      if (monClearAddr) begin
        if (gloA == monAddr) gloV <= 1'b0;
        if (locA == monAddr) locV <= 1'b0;
      end
      if (stealReq) gloV <= 1'b0;
    end
  end

  int checks = 0, errors = 0;
  logic expStatus = 1'b0;
  logic [31:0] expW0 = '0, expW1 = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic steal();
    @(negedge clk) stealReq = 1'b1;
    @(negedge clk) stealReq = 1'b0;
  endtask

  task automatic doOp(input bit st, input logic [31:0] a, input logic [31:0] d0,
                      input logic [31:0] d1, input bit sh, input int errB);
    bit mis, pass, pLocV, pGloV, eLocV, eGloV;
    logic [31:0] pLocA, pGloA, m0, m1, e0, e1;
    int b0, a0, l0, p0, q0, expBeats, waitN;
    @(negedge clk);
    mis = (a[2:0] != 3'b0);
    pLocV = locV; pLocA = locA; pGloV = gloV; pGloA = gloA;
    m0 = mem[a[5:2]]; m1 = mem[a[5:2] + 4'd1];
    pass = pLocV && pLocA == a && (!sh || (pGloV && pGloA == a));
    b0 = beatTotal; a0 = addrErrs; l0 = lockErrs; p0 = pulseTotal; q0 = queryTotal;
    opStart = beatTotal; opBase = a; errBeatSel = errB;
    reqValid = 1'b1; reqIsStore = st; reqAddr = a; reqWord0 = d0; reqWord1 = d1; reqShared = sh;
    check(reqReady == 1'b1, "R10 ready when idle", 32'(reqReady), 32'd1);
    @(negedge clk) reqValid = 1'b0;
    waitN = 0;
    while (!doneValid && waitN < 60) begin @(negedge clk); waitN++; end
    check(doneValid == 1'b1, "R10 done pulse", 32'(doneValid), 32'd1);
    // expected outcome
    eLocV = pLocV; eGloV = pGloV; e0 = m0; e1 = m1;
    if (mis) expBeats = 0;
    else if (st && !pass) begin expBeats = 0; expStatus = 1'b1; eLocV = 1'b0; end
    else if (errB != 0) expBeats = errB;
    else begin
      expBeats = 2;
      if (st) begin
        expStatus = 1'b0; e0 = d0; e1 = d1; eLocV = 1'b0;
        if (sh && pGloA == a) eGloV = 1'b0;
      end else begin
        expW0 = m0; expW1 = m1; eLocV = 1'b1;
        if (sh) eGloV = 1'b1;
      end
    end
    if (!mis && st && errB == 2 && pass) e0 = d0;
    check(doneFault == mis, "R1 fault flag", 32'(doneFault), 32'(mis));
    check(doneAbort == (!mis && errB != 0 && (!st || pass)), "R8 abort flag",
          32'(doneAbort), 32'(!mis && errB != 0 && (!st || pass)));
    check(doneStatus == expStatus, "R6 status", 32'(doneStatus), 32'(expStatus));
    check(doneWord0 == expW0, "R2 load word0", doneWord0, expW0);
    check(doneWord1 == expW1, "R2 load word1", doneWord1, expW1);
    @(negedge clk);
    check(beatTotal - b0 == expBeats, "R9 beat count", 32'(beatTotal - b0), 32'(expBeats));
    check(addrErrs == a0, "R2 beat address", 32'(addrErrs - a0), 32'd0);
    check(lockErrs == l0, "R3 lock", 32'(lockErrs - l0), 32'd0);
    check(queryTotal - q0 == ((st && !mis) ? 1 : 0), "R5 query count",
          32'(queryTotal - q0), 32'((st && !mis) ? 1 : 0));
    if (mis || errB != 0)
      check(pulseTotal == p0 || (st && !pass && !mis), "R1 R8 no monitor action",
            32'(pulseTotal - p0), 32'd0);
    check(locV == eLocV, "R4 R7 local monitor", 32'(locV), 32'(eLocV));
    check(gloV == eGloV, "R4 R7 global monitor", 32'(gloV), 32'(eGloV));
    if (!mis && !(st && !pass) && errB == 0 && !st)
      check(locA == a, "R4 mark address", locA, a);
    if (st && !mis) begin
      check(mem[a[5:2]] == e0, "R2 R9 memory word0", mem[a[5:2]], e0);
      check(mem[a[5:2] + 4'd1] == e1, "R2 R9 memory word1", mem[a[5:2] + 4'd1], e1);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    check(1'b0, "R10 watchdog", 32'(wd), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R10 reset state
    check(reqReady == 1'b1 && doneValid == 1'b0, "R10 reset handshake", 32'({reqReady, doneValid}), 32'h2);
    check(busReq == 1'b0 && busLock == 1'b0, "R10 reset bus idle", 32'({busReq, busLock}), 32'h0);
    check(doneStatus == 1'b0 && doneWord0 == '0 && doneWord1 == '0, "R10 reset results",
          doneWord0 | doneWord1 | 32'(doneStatus), 32'h0);
    // directed corners
    doOp(1'b1, 32'h10, 32'h1111_0000, 32'h2222_0000, 1'b0, 0); // R5 R6 store without reservation
    doOp(1'b0, 32'h10, 32'h0, 32'h0, 1'b1, 0);                 // R4 shared load
    doOp(1'b1, 32'h10, 32'h3333_0000, 32'h4444_0000, 1'b1, 0); // R7 shared store success
    doOp(1'b0, 32'h13, 32'h0, 32'h0, 1'b0, 0);                 // R1 misaligned load
    doOp(1'b1, 32'h0C, 32'h5, 32'h6, 1'b1, 0);                 // R1 misaligned store
    doOp(1'b0, 32'h08, 32'h0, 32'h0, 1'b0, 1);                 // R8 abort first load beat
    doOp(1'b0, 32'h08, 32'h0, 32'h0, 1'b0, 2);                 // R8 abort second load beat
    doOp(1'b0, 32'h18, 32'h0, 32'h0, 1'b1, 0);
    doOp(1'b1, 32'h18, 32'h7777_0000, 32'h8888_0000, 1'b1, 1); // R9 abort first store beat
    doOp(1'b1, 32'h18, 32'h7777_0000, 32'h8888_0000, 1'b1, 2); // R9 abort second store beat
    steal();
    doOp(1'b1, 32'h18, 32'h9, 32'hA, 1'b1, 0);                 // R5 global stolen, refused
    doOp(1'b0, 32'h00, 32'h0, 32'h0, 1'b1, 0);
    steal();
    doOp(1'b1, 32'h00, 32'hB, 32'hC, 1'b0, 0);                 // R5 unshared ignores global
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int eb;
      a = 32'(($urandom % 4) * 8);
      if ($urandom % 8 == 0) a = a + 32'(1 + $urandom % 7);
      eb = ($urandom % 6 == 0) ? int'(1 + $urandom % 2) : 0;
      if ($urandom % 6 == 0) steal();
      doOp(($urandom % 2) == 1, a, $urandom, $urandom, ($urandom % 2) == 1, eb);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule